// File: doc/BRIEF.md
# Sixteen-Bit Register Execute Unit

This block computes the write-back value for the destination register of a small processor with sixteen-bit registers. For each operation it takes the destination register's current value, a second register value, the current program counter and an eight-bit immediate. It then returns the single word that replaces the destination. The operations are the usual arithmetic and logic between two registers, a program-counter-relative add, single-register arithmetic, shifts and a rotate by an immediate count, single-bit clear, set, toggle and extract, a signed immediate add, a register copy, and immediate loads that fill one byte of the register and keep the other.

The arithmetic is purely combinational, split into one unit per operation class. A registered stage with a valid/ready handshake wraps it, so results can be taken one at a time. The operation is named by a 2-bit class and a 3-bit opcode. Any code with no assigned meaning returns the destination value unchanged.

Top module: `rx16_exec`

## Requirements
- R1: With class 0 (two-register), opcodes 0 add, 1 subtract (destination minus second), 3 AND, 4 OR and 5 XOR combine the destination and second operand. Add and subtract wrap modulo 2^16.
- R2: Class 0, opcode 2 returns the program counter plus the second operand, modulo 2^16. The destination value does not enter the result.
- R3: With class 1 (one-register), opcode 0 returns destination+1, opcode 1 returns destination-1 and opcode 2 returns 0-destination, all wrapping. Opcode 3 returns the bitwise complement.
- R4: With class 2 (compact), the count is immediate bits 3:0. Opcode 0 is a logical left shift, opcode 1 a logical right shift, and opcode 2 an arithmetic right shift that copies bit 15 into the vacated bits. A count of 0 leaves the value unchanged.
- R5: Class 2, opcode 3 rotates the destination left by immediate bits 3:0. Bits leaving bit 15 re-enter at bit 0.
- R6: Class 2 opcodes 4, 5 and 6 clear, set and toggle the one bit of the destination indexed by immediate bits 3:0. All other bits are kept.
- R7: Class 2, opcode 7 returns the destination ANDed with a one-hot mask at the bit indexed by immediate bits 3:0. The kept bit stays in its position.
- R8: With class 3 (other), opcode 2 puts the immediate in bits 7:0 and keeps bits 15:8. Opcode 3 puts the immediate in bits 15:8 and keeps bits 7:0.
- R9: Class 3, opcode 0 sign-extends the eight-bit immediate from its bit 7 and adds it to the destination, wrapping.
- R10: Class 3, opcode 1 returns the second operand unchanged.
- R11: Unassigned codes return the destination value unchanged. These are class 0 opcodes 6-7, class 1 opcodes 4-7 and class 3 opcodes 4-7.
- R12: A result is captured on a rising edge where in_valid and in_ready are both high. out_valid and out_data then hold until a rising edge with out_ready high. in_ready is high whenever the output stage is empty or is being drained.
- R13: A synchronous reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Stage can accept an operation |
| in_cls | input | 2 | Operation class |
| in_op | input | 3 | Opcode within the class |
| in_rd | input | 16 | Destination register value |
| in_rs | input | 16 | Second register value |
| in_pc | input | 16 | Program counter |
| in_imm | input | 8 | Immediate |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Write-back value |

## Verification
The combinational checks inside the core assume that every operand and code input carries a known value. They skip evaluation while any of them is unknown. The handshake properties assume that the consumer drives out_ready every cycle and that the producer keeps its fields steady while in_valid waits. The stimulus sets every input to a defined value before the first edge and changes it only on falling edges. It moves on to a new operation only after it has seen in_ready high. out_ready follows a fixed stall pattern, and in one phase it is held low so that the hold and reset behaviour can be observed.

// File: rtl/rx16_pkg.sv
package rx16_pkg;
   typedef enum logic [1:0] {
      CLS_PAIR  = 2'd0,
      CLS_UNARY = 2'd1,
      CLS_IMM   = 2'd2,
      CLS_MISC  = 2'd3
   } cls_e;

   localparam logic [2:0] P_ADD  = 3'd0;
   localparam logic [2:0] P_SUB  = 3'd1;
   localparam logic [2:0] P_PCA  = 3'd2;
   localparam logic [2:0] P_AND  = 3'd3;
   localparam logic [2:0] P_OR   = 3'd4;
   localparam logic [2:0] P_XOR  = 3'd5;

   localparam logic [2:0] U_INC  = 3'd0;
   localparam logic [2:0] U_DEC  = 3'd1;
   localparam logic [2:0] U_NEG  = 3'd2;
   localparam logic [2:0] U_INV  = 3'd3;

   localparam logic [2:0] I_SHL  = 3'd0;
   localparam logic [2:0] I_SHR  = 3'd1;
   localparam logic [2:0] I_SAR  = 3'd2;
   localparam logic [2:0] I_ROL  = 3'd3;
   localparam logic [2:0] I_BCLR = 3'd4;
   localparam logic [2:0] I_BSET = 3'd5;
   localparam logic [2:0] I_BTOG = 3'd6;
   localparam logic [2:0] I_BEXT = 3'd7;

   localparam logic [2:0] M_ADDI = 3'd0;
   localparam logic [2:0] M_COPY = 3'd1;
   localparam logic [2:0] M_LDLO = 3'd2;
   localparam logic [2:0] M_LDHI = 3'd3;
endpackage

// File: rtl/rx16_pair.sv
module rx16_pair
   import rx16_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] pc,
   output logic [DATA_W-1:0] res
);
   always_comb begin
      unique case (op)
         P_ADD:   res = a + b;
         P_SUB:   res = a - b;
         P_PCA:   res = pc + b;
         P_AND:   res = a & b;
         P_OR:    res = a | b;
         P_XOR:   res = a ^ b;
         default: res = a;
      endcase
   end
endmodule

// File: rtl/rx16_unary.sv
module rx16_unary
   import rx16_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a,
   output logic [DATA_W-1:0] res
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   always_comb begin
      unique case (op)
         U_INC:   res = a + ONE;
         U_DEC:   res = a - ONE;
         U_NEG:   res = '0 - a;
         U_INV:   res = ~a;
         default: res = a;
      endcase
   end
endmodule

// File: rtl/rx16_shbit.sv
module rx16_shbit
   import rx16_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit ROT_STAGED = 1'b1,
   localparam int CNT_W     = $clog2(DATA_W)
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] rot;
   logic [DATA_W-1:0] mask;

   generate
      if (ROT_STAGED) begin : g_rot_log
         logic [DATA_W-1:0] stg [0:CNT_W];
         assign stg[0] = a;
         for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            localparam int STEP = 2 ** k;
            assign stg[k+1] = cnt[k]
               ? {stg[k][DATA_W-1-STEP:0], stg[k][DATA_W-1:DATA_W-STEP]}
               : stg[k];
         end
         assign rot = stg[CNT_W];
      end else begin : g_rot_wide
         logic [2*DATA_W-1:0] dbl;
         assign dbl = {a, a} << cnt;
         assign rot = dbl[2*DATA_W-1:DATA_W];
      end
   endgenerate

   assign mask = DATA_W'(1) << cnt;

   always_comb begin
      unique case (op)
         I_SHL:   res = a << cnt;
         I_SHR:   res = a >> cnt;
         I_SAR:   res = DATA_W'($signed(a) >>> cnt);
         I_ROL:   res = rot;
         I_BCLR:  res = a & ~mask;
         I_BSET:  res = a | mask;
         I_BTOG:  res = a ^ mask;
         default: res = a & mask;
      endcase
   end
endmodule

// File: rtl/rx16_misc.sv
module rx16_misc
   import rx16_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IMM_W  = 8,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] imm_sx;
   assign imm_sx = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

   always_comb begin
      unique case (op)
         M_ADDI:  res = a + imm_sx;
         M_COPY:  res = b;
         M_LDLO:  res = {a[DATA_W-1:HALF_W], imm};
         M_LDHI:  res = {imm, a[HALF_W-1:0]};
         default: res = a;
      endcase
   end
endmodule

// File: rtl/rx16_core.sv
module rx16_core
   import rx16_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int IMM_W      = 8,
   parameter bit ROT_STAGED = 1'b1,
   localparam int CNT_W     = $clog2(DATA_W)
) (
   input  logic [1:0]        cls,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] rd,
   input  logic [DATA_W-1:0] rs,
   input  logic [DATA_W-1:0] pc,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] r_pair, r_un, r_sb, r_misc;
   logic [CNT_W-1:0]  cnt;

   assign cnt = imm[CNT_W-1:0];

   rx16_pair #(.DATA_W(DATA_W)) u_pair (
      .op(op), .a(rd), .b(rs), .pc(pc), .res(r_pair));
   rx16_unary #(.DATA_W(DATA_W)) u_unary (
      .op(op), .a(rd), .res(r_un));
   rx16_shbit #(.DATA_W(DATA_W), .ROT_STAGED(ROT_STAGED)) u_shbit (
      .op(op), .a(rd), .cnt(cnt), .res(r_sb));
   rx16_misc #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_misc (
      .op(op), .a(rd), .b(rs), .imm(imm), .res(r_misc));

   always_comb begin
      unique case (cls_e'(cls))
         CLS_PAIR:  res = r_pair;
         CLS_UNARY: res = r_un;
         CLS_IMM:   res = r_sb;
         default:   res = r_misc;
      endcase
   end

   logic known;
   assign known = !$isunknown({cls, op, rd, rs, pc, imm});

   always_comb begin
      if (known) begin
         // R11: unassigned codes keep the destination
         if ((cls == CLS_PAIR && op > P_XOR) || (cls == CLS_UNARY && op > U_INV) ||
             (cls == CLS_MISC && op > M_LDHI))
            a_r11_unused_keeps: assert (res == rd);
         // R3: negation sums with its operand to zero
         if (cls == CLS_UNARY && op == U_NEG)
            a_r3_neg_sums_zero: assert (DATA_W'(res + rd) == '0);
         // R6: set leaves the indexed bit high
         if (cls == CLS_IMM && op == I_BSET)
            a_r6_set_bit_high: assert (res[cnt] == 1'b1);
         // R7: extract keeps at most one bit
         if (cls == CLS_IMM && op == I_BEXT)
            a_r7_extract_onebit: assert ($countones(res) <= 1);
      end
   end
endmodule

// File: rtl/rx16_exec.sv
module rx16_exec #(
   parameter int DATA_W     = 16,
   parameter int IMM_W      = 8,
   parameter bit ROT_STAGED = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [1:0]        in_cls,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] in_rd,
   input  logic [DATA_W-1:0] in_rs,
   input  logic [DATA_W-1:0] in_pc,
   input  logic [IMM_W-1:0]  in_imm,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (DATA_W % 2 != 0 || DATA_W < 4) begin : g_bad_width
         $error("rx16_exec: DATA_W must be even and at least 4");
      end
      if (IMM_W != DATA_W / 2) begin : g_bad_imm
         $error("rx16_exec: IMM_W must equal half of DATA_W");
      end
      if ((1 << $clog2(DATA_W)) != DATA_W) begin : g_bad_pow2
         $error("rx16_exec: DATA_W must be a power of two");
      end
   endgenerate

   logic [DATA_W-1:0] res;

   rx16_core #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_STAGED(ROT_STAGED)) u_core (
      .cls(in_cls), .op(in_op), .rd(in_rd), .rs(in_rs), .pc(in_pc),
      .imm(in_imm), .res(res));

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_valid && in_ready) begin
         out_valid <= 1'b1;
         out_data  <= res;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R12: a stalled result stays put
   a_r12_hold_stalled: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   // R12: an accepted operation yields a result next cycle
   a_r12_accept_gives_valid: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid);
   // R12: drained and nothing new means empty
   a_r12_drain_empties: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && !in_valid |=> !out_valid);
   // R13: reset leaves the stage empty
   a_r13_reset_clears: assert property (@(posedge clk)
      rst |=> !out_valid);
endmodule

// File: tb/tb_rx16_exec.sv
module tb_rx16_exec;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_cls = '0;
   logic [2:0]  in_op = '0;
   logic [15:0] in_rd = '0, in_rs = '0, in_pc = '0;
   logic [7:0]  in_imm = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [15:0] out_data;

   always #2 clk = ~clk;  // 250 MHz

   rx16_exec dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_cls(in_cls), .in_op(in_op), .in_rd(in_rd), .in_rs(in_rs),
      .in_pc(in_pc), .in_imm(in_imm), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data));

   typedef struct { logic [15:0] val; string req; } exp_t;
   exp_t q[$];
   int checks = 0, fails = 0, cyc = 0;
   bit stall = 1'b0, done = 1'b0;

   function automatic logic [15:0] model(int c, int o, logic [15:0] a, logic [15:0] b,
                                         logic [15:0] p, logic [7:0] i);
      logic [3:0]  s = i[3:0];
      logic [15:0] m = 16'(1) << s;
      case (c)
         0: case (o)
               0: return a + b;   1: return a - b;  2: return p + b;
               3: return a & b;   4: return a | b;  5: return a ^ b;
               default: return a;
            endcase
         1: case (o)
               0: return a + 16'd1; 1: return a - 16'd1;
               2: return 16'd0 - a; 3: return ~a;
               default: return a;
            endcase
         2: case (o)
               0: return a << s;  1: return a >> s;
               2: return 16'($signed(a) >>> s);
               3: return (a << s) | 16'({16'd0, a} >> (16 - int'(s)));
               4: return a & ~m;  5: return a | m;  6: return a ^ m;
               default: return a & m;
            endcase
         default: case (o)
               0: return a + {{8{i[7]}}, i};  1: return b;
               2: return {a[15:8], i};        3: return {i, a[7:0]};
               default: return a;
            endcase
      endcase
   endfunction

   function automatic string req_of(int c, int o);
      if (c == 0) return (o == 2) ? "R2" : (o > 5) ? "R11" : "R1";
      if (c == 1) return (o > 3) ? "R11" : "R3";
      if (c == 2) return (o < 3) ? "R4" : (o == 3) ? "R5" : (o == 7) ? "R7" : "R6";
      return (o == 0) ? "R9" : (o == 1) ? "R10" : (o < 4) ? "R8" : "R11";
   endfunction

   task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(int c, int o, logic [15:0] a, logic [15:0] b,
                       logic [15:0] p, logic [7:0] i);
      exp_t e;
      @(negedge clk);
      in_cls = 2'(c); in_op = 3'(o); in_rd = a; in_rs = b; in_pc = p; in_imm = i;
      in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      e.val = model(c, o, a, b, p, i);
      e.req = req_of(c, o);
      q.push_back(e);
   endtask

   // monitor: chooses out_ready at the falling edge, then pops on a transfer
   initial begin
      forever begin
         exp_t e;
         @(negedge clk);
         cyc++;
         out_ready = stall ? 1'b0 : (cyc % 3 != 0);
         #0.5;
         if (out_valid && out_ready && !rst) begin
            if (q.size() == 0) check(1'b0, "R12 spurious result", out_data, 16'hxxxx);
            else begin
               e = q.pop_front();
               check(out_data == e.val, e.req, out_data, e.val);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] av[6] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h1234, 16'h7FFF, 16'hA5C3};
      logic [7:0]  iv[5] = '{8'h00, 8'h0F, 8'h85, 8'h7A, 8'h01};
      logic [15:0] hold_val;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R13: empty after reset, R12: ready when empty
      check(!out_valid, "R13 out_valid after reset", 16'(out_valid), 16'd0);
      check(in_ready, "R12 in_ready when empty", 16'(in_ready), 16'd1);

      for (int ai = 0; ai < 6; ai++)
         for (int ii = 0; ii < 5; ii++)
            for (int c = 0; c < 4; c++)
               for (int o = 0; o < 8; o++)
                  send(c, o, av[ai], av[(ai + 3) % 6] ^ 16'(ii), 16'hFFF0 + 16'(ai), iv[ii]);
      @(negedge clk);
      in_valid = 1'b0;
      wait (q.size() == 0);
      check(1'b1, "R12 queue drained", 16'd0, 16'd0);

      // R12: stalled result is held unchanged
      @(negedge clk);
      stall = 1'b1;
      repeat (2) @(negedge clk);
      send(3, 3, 16'h12CD, 16'h0, 16'h0, 8'hAB);  // R8 high byte load
      hold_val = 16'hABCD;
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         #1;
         check(out_valid, "R12 valid held under stall", 16'(out_valid), 16'd1);
         check(out_data == hold_val, "R12 data held under stall", out_data, hold_val);
         @(negedge clk);
      end
      #1;
      check(!in_ready, "R12 not ready while full and stalled", 16'(in_ready), 16'd0);
      // R13: synchronous reset drops the pending result
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check(!out_valid, "R13 reset clears held result", 16'(out_valid), 16'd0);
      q.delete();
      stall = 1'b0;
      repeat (4) @(negedge clk);
      #1;
      check(!out_valid, "R13 stays empty after reset", 16'(out_valid), 16'd0);
      finish_run();
   end
endmodule